// File: doc/BRIEF.md
# Decode-Stage Branch Redirect Checker

This block sits in the decode stage and looks at a bundle of up to `WIDTH` instructions that fetch has delivered. Each slot comes with the front end's prediction: a predicted-taken flag and a predicted next PC. It also carries the instruction's class flags (control, direct, unconditional), its decoded branch target, its PC, its thread and its sequence number. Direct unconditional jumps have a target that is already known at decode, so they are resolved here and do not wait for execute. The block catches two kinds of wrong prediction. The first is an instruction that was predicted taken but is not a control instruction. The second is a direct unconditional jump whose target differs from the predicted next PC.

The slots are examined in program order, and the first wrong prediction ends the bundle. Slots up to and including the offending one are forwarded to rename. Later slots of the same thread that are younger than the offender are marked killed. A redirect record goes back to fetch and carries the corrected next PC, the PC after it, the taken direction, the thread and the sequence-number threshold for the squash. Forwarded instructions with no source operands are marked as ready to issue. Two per-cycle counts report the branches resolved and the mispredicts detected. All results are registered and appear one clock after the bundle is presented.

Top module: `decode_redirect`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is zero on the next cycle, whatever the inputs are.
- R2: A valid slot with `in_pred_taken`=1 and `in_is_ctrl`=0 raises a redirect with `rd_nonctrl`=1, `rd_taken`=0, `rd_npc` equal to its PC plus `ISZ`, and `rd_seq`/`rd_tid` taken from that slot.
- R3: A valid slot with control, direct and unconditional all set, whose `in_target` differs from `in_pred_npc`, raises a redirect with `rd_nonctrl`=0, `rd_npc` equal to the target and `rd_nnpc` equal to the target plus `ISZ`.
- R4: On a target redirect, `rd_taken` is 1 exactly when the target differs from the slot PC plus `ISZ`. On a non-control redirect, `rd_taken` is 0.
- R5: A direct unconditional slot whose target matches the prediction raises no redirect. A conditional branch (`in_is_uncond`=0) or an indirect one (`in_is_direct`=0) never raises a redirect and is never counted as resolved.
- R6: Only the lowest-index slot that raises a redirect defines the record. `out_fwd` bit i is set for every valid slot at or below that index and for no slot above it. With no redirect, `out_fwd` equals the valid mask.
- R7: `out_kill` bit i is set only for a valid slot above the redirecting slot that has the same thread as the redirect and a sequence number strictly greater than `rd_seq` (unsigned compare). All other slots have bit i clear.
- R8: `out_ready` bit i equals `in_no_src` for forwarded slots and is 0 for every other slot.
- R9: `cnt_resolved` counts the forwarded direct unconditional control slots. `cnt_mispredict` is 1 in a cycle that carries a redirect and 0 otherwise.
- R10: Results appear on the outputs at the first rising edge after the bundle is driven and not before. Slots with `in_valid`=0 have no effect, and a bundle with no valid slots yields all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | WIDTH | Slot holds an instruction |
| in_tid | input | WIDTH x TID_W | Thread of each slot |
| in_seq | input | WIDTH x SEQ_W | Sequence number of each slot |
| in_pc | input | WIDTH x PC_W | PC of each slot |
| in_pred_taken | input | WIDTH | Front end predicted taken |
| in_pred_npc | input | WIDTH x PC_W | Predicted next PC |
| in_is_ctrl | input | WIDTH | Instruction is a control transfer |
| in_is_direct | input | WIDTH | Target is PC-relative/immediate |
| in_is_uncond | input | WIDTH | Transfer is unconditional |
| in_target | input | WIDTH x PC_W | Decoded branch target |
| in_no_src | input | WIDTH | Instruction reads no source operand |
| out_fwd | output | WIDTH | Slot forwarded to rename |
| out_kill | output | WIDTH | Slot squashed |
| out_ready | output | WIDTH | Forwarded slot ready to issue |
| rd_valid | output | 1 | Redirect record valid (mispredict, squash) |
| rd_nonctrl | output | 1 | Cause: non-control predicted taken |
| rd_taken | output | 1 | Actual direction of the redirecting slot |
| rd_tid | output | TID_W | Thread of the redirect |
| rd_seq | output | SEQ_W | Squash threshold sequence number |
| rd_npc | output | PC_W | Corrected next PC |
| rd_nnpc | output | PC_W | Corrected next PC plus ISZ |
| cnt_resolved | output | CNT_W | Branches resolved this cycle |
| cnt_mispredict | output | CNT_W | Mispredicts detected this cycle |

## Verification
Every output is one register stage past the inputs. A bundle driven on a falling edge is checked on the next falling edge, after the single capturing rising edge and before the next bundle can reach the outputs. The latency scenario also samples the outputs right after a bundle is driven, while they still show the previous idle result. Expected values come from hand-worked PC arithmetic and from slot order in each directed task.

// File: rtl/dr_pkg.sv
// Package: shared verdict type for the decode redirect checker.
// Assumes: nothing beyond SystemVerilog packed structs.
package dr_pkg;
    typedef struct packed {
        logic live;      // slot carries an instruction
        logic resolved;  // direct unconditional control, resolved here
        logic redirect;  // slot needs a fetch redirect
        logic nonctrl;   // cause is non-control predicted taken
        logic taken;     // actual direction for a target redirect
    } verdict_t;
endpackage

// File: rtl/dr_slot_check.sv
// Module: dr_slot_check
// Judges one bundle slot: detects the two mispredict kinds and works out
// the corrected next PC. Purely combinational.
// Assumes: target is the decoded target for direct control instructions.
module dr_slot_check
    import dr_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int ISZ  = 4
) (
    input  logic            valid,
    input  logic [PC_W-1:0] pc,
    input  logic            pred_taken,
    input  logic [PC_W-1:0] pred_npc,
    input  logic            is_ctrl,
    input  logic            is_direct,
    input  logic            is_uncond,
    input  logic [PC_W-1:0] target,
    output verdict_t        vd,
    output logic [PC_W-1:0] fix_npc
);
    logic [PC_W-1:0] seq_pc;
    logic            dir_unc;
    logic            bad_kind;
    logic            bad_tgt;

    // Evaluate both mispredict conditions and the correct continuation.
    always_comb begin
        seq_pc      = pc + PC_W'(ISZ);
        dir_unc     = valid & is_ctrl & is_direct & is_uncond;
        bad_kind    = valid & pred_taken & ~is_ctrl;
        bad_tgt     = dir_unc & (target != pred_npc);
        vd.live     = valid;
        vd.resolved = dir_unc;
        vd.redirect = bad_kind | bad_tgt;
        vd.nonctrl  = bad_kind;
        vd.taken    = bad_tgt & (target != seq_pc);
        fix_npc     = bad_kind ? seq_pc : target;
    end
endmodule

// File: rtl/dr_first_pick.sv
// Module: dr_first_pick
// Scans slot verdicts in program order, picks the first redirect and
// builds the forward mask and the mask of slots behind the redirect.
// Assumes: a verdict with redirect set also has live set.
module dr_first_pick
    import dr_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int IDX_W = 2
) (
    input  verdict_t          vd [WIDTH],
    output logic              any,
    output logic [IDX_W-1:0]  idx,
    output logic [WIDTH-1:0]  fwd,
    output logic [WIDTH-1:0]  behind
);
    logic stop;

    // Linear prefix scan: everything after the first redirect is cut off.
    always_comb begin
        stop   = 1'b0;
        idx    = '0;
        fwd    = '0;
        behind = '0;
        for (int i = 0; i < WIDTH; i++) begin
            behind[i] = stop;
            fwd[i]    = vd[i].live & ~stop;
            if (vd[i].redirect && !stop)
                idx = IDX_W'(i);
            stop = stop | vd[i].redirect;
        end
        any = stop;
    end
endmodule

// File: rtl/decode_redirect.sv
// Module: decode_redirect (top)
// Checks a decode bundle against branch predictions, resolves direct
// unconditional jumps, and registers the forward/kill/ready masks, the
// fetch redirect record and per-cycle counts. One cycle latency.
// Assumes: sequence numbers do not wrap within a bundle's lifetime.
module decode_redirect
    import dr_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int PC_W  = 32,
    parameter int SEQ_W = 16,
    parameter int TID_W = 2,
    parameter int ISZ   = 4,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WIDTH-1:0]            in_valid,
    input  logic [WIDTH-1:0][TID_W-1:0] in_tid,
    input  logic [WIDTH-1:0][SEQ_W-1:0] in_seq,
    input  logic [WIDTH-1:0][PC_W-1:0]  in_pc,
    input  logic [WIDTH-1:0]            in_pred_taken,
    input  logic [WIDTH-1:0][PC_W-1:0]  in_pred_npc,
    input  logic [WIDTH-1:0]            in_is_ctrl,
    input  logic [WIDTH-1:0]            in_is_direct,
    input  logic [WIDTH-1:0]            in_is_uncond,
    input  logic [WIDTH-1:0][PC_W-1:0]  in_target,
    input  logic [WIDTH-1:0]            in_no_src,
    output logic [WIDTH-1:0]            out_fwd,
    output logic [WIDTH-1:0]            out_kill,
    output logic [WIDTH-1:0]            out_ready,
    output logic                        rd_valid,
    output logic                        rd_nonctrl,
    output logic                        rd_taken,
    output logic [TID_W-1:0]            rd_tid,
    output logic [SEQ_W-1:0]            rd_seq,
    output logic [PC_W-1:0]             rd_npc,
    output logic [PC_W-1:0]             rd_nnpc,
    output logic [CNT_W-1:0]            cnt_resolved,
    output logic [CNT_W-1:0]            cnt_mispredict
);
    verdict_t         vd      [WIDTH];
    logic [PC_W-1:0]  fix_npc [WIDTH];
    logic             any_rd;
    logic [IDX_W-1:0] rd_idx;
    logic [WIDTH-1:0] fwd_c;
    logic [WIDTH-1:0] behind_c;
    logic [WIDTH-1:0] kill_c;
    logic [CNT_W-1:0] res_c;
    logic [TID_W-1:0] sel_tid;
    logic [SEQ_W-1:0] sel_seq;

    // One checker per slot.
    for (genvar g = 0; g < WIDTH; g++) begin : g_slot
        dr_slot_check #(.PC_W(PC_W), .ISZ(ISZ)) u_slot (
            .valid      (in_valid[g]),
            .pc         (in_pc[g]),
            .pred_taken (in_pred_taken[g]),
            .pred_npc   (in_pred_npc[g]),
            .is_ctrl    (in_is_ctrl[g]),
            .is_direct  (in_is_direct[g]),
            .is_uncond  (in_is_uncond[g]),
            .target     (in_target[g]),
            .vd         (vd[g]),
            .fix_npc    (fix_npc[g])
        );
    end

    dr_first_pick #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_pick (
        .vd     (vd),
        .any    (any_rd),
        .idx    (rd_idx),
        .fwd    (fwd_c),
        .behind (behind_c)
    );

    // Squash marking against the chosen threshold, and resolved count.
    always_comb begin
        sel_tid = in_tid[rd_idx];
        sel_seq = in_seq[rd_idx];
        res_c   = '0;
        for (int i = 0; i < WIDTH; i++) begin
            kill_c[i] = behind_c[i] & in_valid[i] & (in_tid[i] == sel_tid)
                        & (in_seq[i] > sel_seq);
            res_c     = res_c + CNT_W'(fwd_c[i] & vd[i].resolved);
        end
    end

    // Register every result; reset clears all outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_fwd        <= '0;
            out_kill       <= '0;
            out_ready      <= '0;
            rd_valid       <= 1'b0;
            rd_nonctrl     <= 1'b0;
            rd_taken       <= 1'b0;
            rd_tid         <= '0;
            rd_seq         <= '0;
            rd_npc         <= '0;
            rd_nnpc        <= '0;
            cnt_resolved   <= '0;
            cnt_mispredict <= '0;
        end else begin
            out_fwd        <= fwd_c;
            out_kill       <= any_rd ? kill_c : '0;
            out_ready      <= fwd_c & in_no_src;
            rd_valid       <= any_rd;
            rd_nonctrl     <= any_rd & vd[rd_idx].nonctrl;
            rd_taken       <= any_rd & vd[rd_idx].taken;
            rd_tid         <= any_rd ? sel_tid : '0;
            rd_seq         <= any_rd ? sel_seq : '0;
            rd_npc         <= any_rd ? fix_npc[rd_idx] : '0;
            rd_nnpc        <= any_rd ? fix_npc[rd_idx] + PC_W'(ISZ) : '0;
            cnt_resolved   <= res_c;
            cnt_mispredict <= CNT_W'(any_rd);
        end
    end
endmodule

// File: rtl/decode_redirect_chk.sv
// Module: decode_redirect_chk
// Property checker for decode_redirect, attached by bind below.
// Assumes: same parameter values as the bound instance.
module decode_redirect_chk #(
    parameter int WIDTH = 4,
    parameter int PC_W  = 32,
    parameter int ISZ   = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] in_valid,
    input logic [WIDTH-1:0] out_fwd,
    input logic [WIDTH-1:0] out_kill,
    input logic [WIDTH-1:0] out_ready,
    input logic             rd_valid,
    input logic             rd_nonctrl,
    input logic             rd_taken,
    input logic [PC_W-1:0]  rd_npc,
    input logic [PC_W-1:0]  rd_nnpc,
    input logic [CNT_W-1:0] cnt_resolved,
    input logic [CNT_W-1:0] cnt_mispredict
);
    AST_NNPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_nnpc == rd_npc + PC_W'(ISZ)); // R3
    AST_NONCTRL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_nonctrl) |-> !rd_taken); // R4
    AST_FWD_KILL_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fwd & out_kill) == '0); // R7
    AST_KILL_NEEDS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_kill) |-> rd_valid); // R7
    AST_READY_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready & ~out_fwd) == '0); // R8
    AST_MIS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_mispredict == CNT_W'(rd_valid)); // R9
    AST_RESOLVED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_resolved) <= $countones(out_fwd)); // R9
    AST_FWD_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fwd & ~$past(in_valid)) == '0); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) == '0) |-> !rd_valid); // R10
endmodule

bind decode_redirect decode_redirect_chk #(
    .WIDTH(WIDTH), .PC_W(PC_W), .ISZ(ISZ), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_fwd(out_fwd),
    .out_kill(out_kill), .out_ready(out_ready), .rd_valid(rd_valid),
    .rd_nonctrl(rd_nonctrl), .rd_taken(rd_taken), .rd_npc(rd_npc),
    .rd_nnpc(rd_nnpc), .cnt_resolved(cnt_resolved),
    .cnt_mispredict(cnt_mispredict)
);

// File: tb/decode_redirect_tb.sv
// Directed bench for decode_redirect: one task per scenario.
module decode_redirect_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]       in_valid, in_pred_taken, in_is_ctrl, in_is_direct;
    logic [W-1:0]       in_is_uncond, in_no_src;
    logic [W-1:0][1:0]  in_tid;
    logic [W-1:0][15:0] in_seq;
    logic [W-1:0][31:0] in_pc, in_pred_npc, in_target;
    logic [W-1:0]       out_fwd, out_kill, out_ready;
    logic               rd_valid, rd_nonctrl, rd_taken;
    logic [1:0]         rd_tid;
    logic [15:0]        rd_seq;
    logic [31:0]        rd_npc, rd_nnpc;
    logic [2:0]         cnt_resolved, cnt_mispredict;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    decode_redirect u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tid(in_tid),
        .in_seq(in_seq), .in_pc(in_pc), .in_pred_taken(in_pred_taken),
        .in_pred_npc(in_pred_npc), .in_is_ctrl(in_is_ctrl),
        .in_is_direct(in_is_direct), .in_is_uncond(in_is_uncond),
        .in_target(in_target), .in_no_src(in_no_src), .out_fwd(out_fwd),
        .out_kill(out_kill), .out_ready(out_ready), .rd_valid(rd_valid),
        .rd_nonctrl(rd_nonctrl), .rd_taken(rd_taken), .rd_tid(rd_tid),
        .rd_seq(rd_seq), .rd_npc(rd_npc), .rd_nnpc(rd_nnpc),
        .cnt_resolved(cnt_resolved), .cnt_mispredict(cnt_mispredict)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_bundle();
        in_valid = '0; in_pred_taken = '0; in_is_ctrl = '0;
        in_is_direct = '0; in_is_uncond = '0; in_no_src = '0;
        in_tid = '0; in_seq = '0; in_pc = '0; in_pred_npc = '0;
        in_target = '0;
    endtask

    task automatic put(int s, logic [1:0] tid, logic [15:0] seq,
                       logic [31:0] pc, logic pt, logic [31:0] pnpc,
                       logic c, logic d, logic u, logic [31:0] tgt,
                       logic nos);
        in_valid[s] = 1'b1; in_tid[s] = tid; in_seq[s] = seq; in_pc[s] = pc;
        in_pred_taken[s] = pt; in_pred_npc[s] = pnpc; in_is_ctrl[s] = c;
        in_is_direct[s] = d; in_is_uncond[s] = u; in_target[s] = tgt;
        in_no_src[s] = nos;
    endtask

    task automatic t_reset();
        clear_bundle();
        put(0, 2'd1, 16'd5, 32'h40, 1'b1, 32'h80, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R1 fwd", out_fwd, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 ready", out_ready, 0);
        chk("R1 cnt_mispredict", cnt_mispredict, 0);
        rst_n = 1'b1;
        clear_bundle();
        @(negedge clk);
    endtask

    task automatic t_nonctrl();
        clear_bundle();
        put(0, 2'd1, 16'd10, 32'h0FC, 1'b0, 32'h100, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
        put(1, 2'd1, 16'd11, 32'h100, 1'b1, 32'h400, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        put(2, 2'd1, 16'd12, 32'h104, 1'b0, 32'h108, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
        put(3, 2'd2, 16'd13, 32'h108, 1'b0, 32'h10C, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        @(negedge clk);
        chk("R2 rd_valid", rd_valid, 1);
        chk("R2 rd_nonctrl", rd_nonctrl, 1);
        chk("R2 rd_npc", rd_npc, 32'h104);
        chk("R2 rd_seq", rd_seq, 11);
        chk("R2 rd_tid", rd_tid, 1);
        chk("R4 nonctrl taken", rd_taken, 0);
        chk("R6 fwd", out_fwd, 4'b0011);
        chk("R7 kill", out_kill, 4'b0100);
        chk("R8 ready", out_ready, 4'b0001);
    endtask

    task automatic t_target_mis();
        clear_bundle();
        put(0, 2'd0, 16'd20, 32'h200, 1'b0, 32'h204, 1'b1, 1'b1, 1'b1, 32'h300, 1'b0);
        put(1, 2'd0, 16'd21, 32'h204, 1'b0, 32'h208, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        put(2, 2'd0, 16'd22, 32'h208, 1'b0, 32'h20C, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        put(3, 2'd0, 16'd3,  32'h20C, 1'b0, 32'h210, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        @(negedge clk);
        chk("R3 rd_valid", rd_valid, 1);
        chk("R3 rd_nonctrl", rd_nonctrl, 0);
        chk("R3 rd_npc", rd_npc, 32'h300);
        chk("R3 rd_nnpc", rd_nnpc, 32'h304);
        chk("R4 taken", rd_taken, 1);
        chk("R7 kill older seq kept", out_kill, 4'b0110);
        chk("R6 fwd", out_fwd, 4'b0001);
        chk("R9 resolved", cnt_resolved, 1);
        chk("R9 mispredict", cnt_mispredict, 1);
    endtask

    task automatic t_target_ok();
        clear_bundle();
        for (int i = 0; i < W; i++)
            put(i, 2'd2, 16'(30 + i), 32'h500 + 32'(16 * i), 1'b1,
                32'h800 + 32'(16 * i), 1'b1, 1'b1, 1'b1,
                32'h800 + 32'(16 * i), 1'b0);
        @(negedge clk);
        chk("R5 no redirect", rd_valid, 0);
        chk("R6 fwd all", out_fwd, 4'b1111);
        chk("R9 resolved", cnt_resolved, 4);
        chk("R9 mispredict", cnt_mispredict, 0);
        chk("R7 no kill", out_kill, 0);
    endtask

    task automatic t_taken_zero();
        clear_bundle();
        put(0, 2'd1, 16'd50, 32'h600, 1'b1, 32'h900, 1'b1, 1'b1, 1'b1, 32'h604, 1'b0);
        @(negedge clk);
        chk("R4 rd_valid", rd_valid, 1);
        chk("R4 fallthrough taken", rd_taken, 0);
        chk("R3 npc", rd_npc, 32'h604);
        chk("R3 nnpc", rd_nnpc, 32'h608);
    endtask

    task automatic t_first_wins();
        clear_bundle();
        put(0, 2'd3, 16'd40, 32'h6FC, 1'b0, 32'h700, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        put(1, 2'd3, 16'd41, 32'h700, 1'b1, 32'hF00, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        put(2, 2'd3, 16'd42, 32'h704, 1'b0, 32'h708, 1'b1, 1'b1, 1'b1, 32'hE00, 1'b1);
        @(negedge clk);
        chk("R6 seq of first", rd_seq, 41);
        chk("R6 cause of first", rd_nonctrl, 1);
        chk("R6 npc of first", rd_npc, 32'h704);
        chk("R6 fwd", out_fwd, 4'b0011);
        chk("R9 resolved behind redirect", cnt_resolved, 0);
        chk("R7 kill", out_kill, 4'b0100);
        chk("R8 ready not forwarded", out_ready, 0);
    endtask

    task automatic t_cond_indirect();
        clear_bundle();
        put(0, 2'd0, 16'd60, 32'h900, 1'b1, 32'hB00, 1'b1, 1'b1, 1'b0, 32'hA00, 1'b0);
        put(1, 2'd0, 16'd61, 32'h904, 1'b1, 32'hD00, 1'b1, 1'b0, 1'b1, 32'hC00, 1'b0);
        @(negedge clk);
        chk("R5 no redirect", rd_valid, 0);
        chk("R5 not resolved", cnt_resolved, 0);
        chk("R6 fwd equals valid", out_fwd, 4'b0011);
    endtask

    task automatic t_invalid_and_latency();
        clear_bundle();
        put(0, 2'd0, 16'd70, 32'hA00, 1'b0, 32'hA04, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
        put(2, 2'd0, 16'd72, 32'hA08, 1'b1, 32'hC00, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        in_valid[2] = 1'b0;
        @(negedge clk);
        chk("R10 invalid ignored", rd_valid, 0);
        chk("R10 fwd", out_fwd, 4'b0001);
        chk("R8 ready", out_ready, 4'b0001);
        clear_bundle();
        put(0, 2'd1, 16'd80, 32'hB00, 1'b1, 32'hC00, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        #1;
        chk("R10 not before edge", rd_valid, 0);
        @(negedge clk);
        chk("R10 after one edge", rd_valid, 1);
        clear_bundle();
        @(negedge clk);
        chk("R10 empty bundle", rd_valid, 0);
        chk("R10 empty fwd", out_fwd, 0);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_bundle();
        @(negedge clk);
        t_reset();
        t_nonctrl();
        t_target_mis();
        t_target_ok();
        t_taken_zero();
        t_first_wins();
        t_cond_indirect();
        t_invalid_and_latency();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule